// File: doc/BRIEF.md
# Bit-field change read-modify-write unit

This unit flips a chosen set of bits in one data word. A 16-bit mask arrives with a start strobe. Each 1 in the mask selects a bit to invert, and each 0 leaves its bit alone. The target word is a data memory location, a general register or the status register. A memory target is handled by a read-modify-write sequence on a synchronous memory port. The unit reads the word, forms the new value, writes it back to the same address and then raises a done pulse. A register target arrives on a value input, and its result goes out on a writeback bus one cycle after start, with no memory traffic.

Each operation also tests the selected bits of the old value. The carry output is 1 when none of those bits was 0. This makes the unit serve both as a bit-field toggle and as an "all selected bits set" test. Instruction decode, address computation and the other flags are handled by the surrounding pipeline.

Top module: `bitflip_rmw`

## Requirements
- R1: The written-back value equals the old destination value XOR the mask, for every value and mask.
- R2: A memory operation (dst_sel_i = 2'b00) makes exactly one read and then one write. The read is asserted in the cycle after start and the write two cycles later. Both use the address that was captured at start.
- R3: carry_o becomes 1 when (old value AND mask) equals the mask, and 0 otherwise. It changes only when an operation computes its result, and it holds its value between operations.
- R4: Old value 16'h5555 with mask 16'h0FF0 gives 16'h5AA5 and carry 0.
- R5: A mask of zero leaves the word unchanged, still makes both memory accesses and sets carry to 1.
- R6: A general register target (dst_sel_i = 2'b01, and 2'b11 behaves the same) raises reg_we_o and done_o in the cycle after start. It issues no memory read or write, and stat_we_o stays low.
- R7: A status register target (dst_sel_i = 2'b10) raises stat_we_o instead of reg_we_o. The written word differs from the old one only in the mask bits, and carry follows the mask test.
- R8: done_o is a single-cycle pulse. For a memory target it comes in the cycle after the write, which is four cycles after start.
- R9: A start strobe while an operation is in progress is ignored. It causes no extra access and no writeback, and the running operation finishes with its own result.
- R10: After reset all strobes (mem_rd_o, mem_wr_o, reg_we_o, stat_we_o, done_o) are low and carry_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts an operation when the unit is idle |
| mask_i | input | W | Bits to invert |
| dst_sel_i | input | 2 | Target: 00 memory, 01/11 general register, 10 status register |
| addr_i | input | AW | Memory address for a memory target |
| reg_val_i | input | W | Current register value for a register target |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | W | Memory write data |
| mem_rdata_i | input | W | Memory read data, valid the cycle after a read |
| reg_we_o | output | 1 | General register writeback strobe |
| stat_we_o | output | 1 | Status register writeback strobe |
| reg_wdata_o | output | W | Register writeback value |
| carry_o | output | 1 | Result of the all-selected-bits-set test |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a start strobe that lands while a memory sequence is in progress. The strobe must be dropped without disturbing the captured address, the mask or the access count. The bench raises start for a register target in the middle of a memory operation. It then confirms that only one read and one write took place, that no register writeback was produced and that the memory word matches the first operation alone. Sweeps over every address of a small memory model, and over many register values and masks, cover the XOR and carry arithmetic. These include the zero mask and the all-ones mask.

// File: rtl/bitflip_pkg.sv
package bitflip_pkg;
  typedef enum logic [1:0] {
    DST_MEM  = 2'b00,
    DST_GPR  = 2'b01,
    DST_STAT = 2'b10,
    DST_ALT  = 2'b11
  } dst_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_MODIFY = 3'd2,
    ST_WRITE  = 3'd3,
    ST_DONE   = 3'd4
  } state_e;
endpackage

// File: rtl/bitflip_alu.sv
module bitflip_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] value_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] result_o,
  output logic         all_set_o
);
  function automatic logic [W-1:0] flip_bits(input logic [W-1:0] v, input logic [W-1:0] m);
    return v ^ m;
  endfunction

  function automatic logic mask_covered(input logic [W-1:0] v, input logic [W-1:0] m);
    return (v & m) == m;
  endfunction

  assign result_o  = flip_bits(value_i, mask_i);
  assign all_set_o = mask_covered(value_i, mask_i);

  // R1
  always_comb begin
    result_xor_chk: assert (((result_o ^ value_i) & ~mask_i) == '0);
  end
endmodule

// File: rtl/bitflip_ctrl.sv
module bitflip_ctrl
  import bitflip_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  logic   dst_is_mem_i,
  output state_e state_o,
  output logic   accept_o,
  output logic   latch_mem_o,
  output logic   latch_reg_o
);
  state_e state_q, state_d;
  logic   idle;

  assign idle        = (state_q == ST_IDLE);
  assign accept_o    = start_i && idle;
  assign latch_mem_o = (state_q == ST_MODIFY);
  assign latch_reg_o = accept_o && !dst_is_mem_i;
  assign state_o     = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept_o) state_d = dst_is_mem_i ? ST_READ : ST_DONE;
      ST_READ:   state_d = ST_MODIFY;
      ST_MODIFY: state_d = ST_WRITE;
      ST_WRITE:  state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));
  // R2
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ) |=> (state_q == ST_MODIFY));
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && start_i && state_q != ST_DONE) |=> (state_q != ST_IDLE));
endmodule

// File: rtl/bitflip_rmw.sv
module bitflip_rmw
  import bitflip_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [W-1:0]  mask_i,
  input  logic [1:0]    dst_sel_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  reg_val_i,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [W-1:0]  mem_wdata_o,
  input  logic [W-1:0]  mem_rdata_i,
  output logic          reg_we_o,
  output logic          stat_we_o,
  output logic [W-1:0]  reg_wdata_o,
  output logic          carry_o,
  output logic          done_o
);
  state_e        state;
  logic          accept, latch_mem, latch_reg, dst_is_mem;
  logic [W-1:0]  mask_q, res_q, alu_val, alu_mask, alu_res;
  logic [AW-1:0] addr_q;
  logic [1:0]    dst_q;
  logic          carry_q, alu_all;

  assign dst_is_mem = (dst_sel_i == DST_MEM);

  bitflip_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .dst_is_mem_i (dst_is_mem),
    .state_o      (state),
    .accept_o     (accept),
    .latch_mem_o  (latch_mem),
    .latch_reg_o  (latch_reg)
  );

  assign alu_val  = latch_reg ? reg_val_i : mem_rdata_i;
  assign alu_mask = latch_reg ? mask_i    : mask_q;

  bitflip_alu #(.W(W)) u_alu (
    .value_i   (alu_val),
    .mask_i    (alu_mask),
    .result_o  (alu_res),
    .all_set_o (alu_all)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      addr_q  <= '0;
      dst_q   <= DST_MEM;
      res_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      if (accept) begin
        mask_q <= mask_i;
        addr_q <= addr_i;
        dst_q  <= dst_sel_i;
      end
      if (latch_reg || latch_mem) begin
        res_q   <= alu_res;
        carry_q <= alu_all;
      end
    end
  end

  assign mem_rd_o    = (state == ST_READ);
  assign mem_wr_o    = (state == ST_WRITE);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = res_q;
  assign done_o      = (state == ST_DONE);
  assign reg_we_o    = done_o && (dst_q == DST_GPR || dst_q == DST_ALT);
  assign stat_we_o   = done_o && (dst_q == DST_STAT);
  assign reg_wdata_o = res_q;
  assign carry_o     = carry_q;

  // R2
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> ($past(mem_rd_o, 2) && mem_addr_o == $past(mem_addr_o, 2)));
  // R1
  wdata_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> ((mem_wdata_o ^ $past(mem_rdata_i)) == mask_q));
  // R6
  reg_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_o || stat_we_o) |-> ($past(accept) && !$past(mem_rd_o)));
endmodule

// File: tb/bitflip_rmw_bench.sv
module bitflip_rmw_bench;
  localparam int W = 16;
  localparam int AW = 16;

  logic clk = 0, rst_n = 0, start = 0;
  logic [W-1:0] mask = 0, reg_val = 0, rdata = 0;
  logic [1:0] sel = 0;
  logic [AW-1:0] addr = 0;
  logic mem_rd, mem_wr, reg_we, stat_we, carry, done;
  logic [AW-1:0] mem_addr;
  logic [W-1:0] wdata, reg_wdata;

  int checks = 0, errors = 0, rd_cnt = 0, wr_cnt = 0;
  bit finished = 0;
  logic [W-1:0] mem [16];
  logic [W-1:0] model [16];

  always #2 clk = ~clk;

  bitflip_rmw #(.W(W), .AW(AW)) u_bitflip_rmw (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mask_i(mask), .dst_sel_i(sel),
    .addr_i(addr), .reg_val_i(reg_val), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_addr_o(mem_addr), .mem_wdata_o(wdata), .mem_rdata_i(rdata),
    .reg_we_o(reg_we), .stat_we_o(stat_we), .reg_wdata_o(reg_wdata),
    .carry_o(carry), .done_o(done));

  always @(posedge clk) begin
    if (mem_rd) begin rdata <= mem[mem_addr[3:0]]; rd_cnt <= rd_cnt + 1; end
    if (mem_wr) begin mem[mem_addr[3:0]] <= wdata; wr_cnt <= wr_cnt + 1; end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_carry(input logic [W-1:0] v, input logic [W-1:0] m);
    return ~|(~v & m);
  endfunction

  task automatic mem_op(input logic [3:0] a, input logic [W-1:0] m, input bit poke_busy);
    logic [W-1:0] old, expv;
    int r0, w0;
    old = model[a];
    expv = old + m - ((old & m) << 1);
    r0 = rd_cnt; w0 = wr_cnt;
    @(negedge clk);
    start = 1; sel = 2'b00; addr = {{(AW-4){1'b0}}, a}; mask = m;
    @(negedge clk);
    start = 0; mask = ~m; addr = ~addr;
    chk(mem_rd && !mem_wr && mem_addr[3:0] == a, "R2 read cycle", {mem_rd, mem_wr, mem_addr[3:0]}, {2'b10, a});
    @(negedge clk);
    if (poke_busy) begin start = 1; sel = 2'b01; reg_val = 16'hFFFF; end
    chk(!mem_rd && !mem_wr && !done, "R2 modify idle bus", {mem_rd, mem_wr, done}, 0);
    @(negedge clk);
    start = 0;
    chk(mem_wr && mem_addr[3:0] == a && wdata == expv, "R1 write data", wdata, expv);
    @(negedge clk);
    chk(done && !reg_we && !stat_we, "R8 done after write", {done, reg_we, stat_we}, 3'b100);
    chk(carry == exp_carry(old, m), "R3 carry", carry, exp_carry(old, m));
    @(negedge clk);
    chk(!done && !reg_we, poke_busy ? "R9 busy start ignored" : "R8 single pulse", {done, reg_we}, 0);
    chk(rd_cnt - r0 == 1 && wr_cnt - w0 == 1, poke_busy ? "R9 access count" : "R2 access count",
        (rd_cnt - r0) * 16 + (wr_cnt - w0), 17);
    chk(mem[a] == expv, "R1 memory word", mem[a], expv);
    model[a] = expv;
  endtask

  task automatic reg_op(input logic [1:0] s, input logic [W-1:0] v, input logic [W-1:0] m);
    logic [W-1:0] expv;
    int r0, w0;
    bit is_stat;
    expv = v + m - ((v & m) << 1);
    is_stat = (s == 2'b10);
    r0 = rd_cnt; w0 = wr_cnt;
    @(negedge clk);
    start = 1; sel = s; reg_val = v; mask = m;
    @(negedge clk);
    start = 0; reg_val = ~v; mask = 0;
    chk(done && reg_we == !is_stat && stat_we == is_stat, is_stat ? "R7 strobe" : "R6 strobe",
        {done, reg_we, stat_we}, {1'b1, !is_stat, is_stat});
    chk(reg_wdata == expv, is_stat ? "R7 only masked bits" : "R1 reg result", reg_wdata, expv);
    chk(carry == exp_carry(v, m), "R3 reg carry", carry, exp_carry(v, m));
    chk(!mem_rd && !mem_wr, "R6 no memory access", {mem_rd, mem_wr}, 0);
    @(negedge clk);
    chk(!done && carry == exp_carry(v, m) && rd_cnt == r0 && wr_cnt == w0, "R3 carry held",
        {done, carry}, {1'b0, exp_carry(v, m)});
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 16'h1357 * i[15:0] ^ 16'hA5C3;
      model[i] = mem[i];
    end
    mem[5] = 16'h5555; model[5] = 16'h5555;
    repeat (3) @(negedge clk);
    chk(!mem_rd && !mem_wr && !reg_we && !stat_we && !done && !carry, "R10 reset state",
        {mem_rd, mem_wr, reg_we, stat_we, done, carry}, 0);
    rst_n = 1;
    @(negedge clk);
    mem_op(4'd5, 16'h0FF0, 0);
    chk(model[5] == 16'h5AA5 && !carry, "R4 example", {model[5], 15'd0, carry}, 32'h5AA50000);
    mem_op(4'd3, 16'h0000, 0);
    chk(carry == 1'b1, "R5 zero mask carry", carry, 1);
    for (int a = 0; a < 16; a++) begin
      mem_op(a[3:0], 16'h0101 << (a % 8), 0);
      mem_op(a[3:0], model[a], 0);
      mem_op(a[3:0], 16'hFFFF, 0);
    end
    mem_op(4'd9, 16'h00F0, 1);
    reg_op(2'b01, 16'h5555, 16'h0FF0);
    chk(reg_wdata == 16'h5AA5 && !carry, "R4 register example", reg_wdata, 16'h5AA5);
    reg_op(2'b01, 16'h1234, 16'h0000);
    chk(carry, "R5 zero mask register", carry, 1);
    for (int i = 0; i < 128; i++) begin
      logic [W-1:0] v, m;
      v = 16'h9E37 * i[15:0] + 16'h0F0F;
      m = (i % 4 == 0) ? (v & (16'h00FF << (i % 9))) : (16'h3C5A * i[15:0]);
      reg_op(i[1:0] == 2'b10 ? 2'b10 : (i[0] ? 2'b11 : 2'b01), v, m);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule